// File: doc/BRIEF.md
# Perfect Address Filter Frame Generator

This block produces the configuration frame that loads a MAC's exact-match address filter. A small table holds up to sixteen 48-bit station addresses. Each entry is written through a plain write port that takes an index, an address and a strobe. A pulse on `start` latches the number of valid entries and sends the whole 192-byte frame as a stream of 32-bit words.

The frame has sixteen slots. Each slot is three words, and each word carries two address bytes in its low half. When fewer than sixteen addresses are configured, the entries are reused in rotation until every slot is filled. The output is a valid/ready stream. A word stays on the bus until the consumer takes it. `ready` may be held low for any number of cycles, and the stream then waits without losing or duplicating a word. The word that closes the frame is flagged with `frm_last`.

Top module: `setup_frame_gen`

## Requirements
- R1: While reset is asserted, and after reset until a start, `frm_valid` and `cfg_err` are 0.
- R2: An accepted start with a nonzero count produces exactly 48 words. `frm_last` is 1 on the 48th word only. `frm_valid` falls in the cycle after the last word is taken.
- R3: Word 3k+j (j = 0, 1, 2) has bits 31:16 equal to zero, address byte 2j in bits 7:0 and address byte 2j+1 in bits 15:8. Address byte i is bits 8i+7:8i of the stored 48-bit value.
- R4: With N configured entries (1 ≤ N ≤ 16), slot k carries table entry k mod N.
- R5: A count above 16 is handled as 16.
- R6: While `frm_valid` is 1 and `frm_ready` is 0, `frm_data` and `frm_last` hold their values. A word advances only when valid and ready are both 1 in the same cycle.
- R7: A start with count 0 emits no word and sets `cfg_err`. The next start with a nonzero count clears `cfg_err`.
- R8: A start that arrives while a frame is in flight is ignored. This includes the cycle in which the last word is taken. The frame in flight continues unchanged, and no second frame follows.
- R9: A write with `tbl_we` = 1 replaces entry `tbl_idx`. The count is sampled in the cycle in which start is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tbl_we | input | 1 | Address table write strobe |
| tbl_idx | input | 4 | Entry index for a write |
| tbl_addr | input | 48 | Address value to store |
| cfg_count | input | 5 | Number of valid entries, sampled at start |
| start | input | 1 | Begin frame generation |
| frm_valid | output | 1 | Output word valid |
| frm_ready | input | 1 | Consumer accepts word |
| frm_data | output | 32 | Output word |
| frm_last | output | 1 | Marks the final word of the frame |
| cfg_err | output | 1 | Set by a start with zero count |

## Verification
The two functions that can meet in one cycle are the acceptance of the final word and a new start request. The bench provokes this by raising `start` exactly when one word remains and `ready` is high. The reference model treats that start as ignored because a frame is still in flight. The per-cycle comparison then expects `frm_valid` to fall and no second frame to begin. Stalls on the final word are also mixed with random back-pressure, and the bench judges that `frm_last` stays on the same held word.

// File: rtl/sfg_pkg.sv
package sfg_pkg;
  localparam int WORDS_PER_SLOT = 3;
  localparam int SEL_W = 2;
  typedef logic [SEL_W-1:0] wsel_t;
endpackage

// File: rtl/sfg_addr_table.sv
module sfg_addr_table #(
  parameter int SLOTS  = 16,
  parameter int ADDR_W = 48,
  parameter int IDX_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [ADDR_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [ADDR_W-1:0] rd_data
);
  logic [ADDR_W-1:0] mem_q [SLOTS];

  for (genvar e = 0; e < SLOTS; e++) begin : g_ent
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        mem_q[e] <= '0;
      else if (we && wr_idx == IDX_W'(e))
        mem_q[e] <= wr_data;
    end
  end

  assign rd_data = mem_q[rd_idx];
endmodule

// File: rtl/sfg_word_format.sv
module sfg_word_format
  import sfg_pkg::*;
#(
  parameter int ADDR_W = 48,
  parameter int WORD_W = 32
) (
  input  logic [ADDR_W-1:0] addr,
  input  wsel_t             wsel,
  output logic [WORD_W-1:0] word
);
  localparam int HALF = WORD_W / 2;
  logic [HALF-1:0] pair;

  always_comb begin
    pair = addr[wsel*HALF +: HALF];
    word = {{(WORD_W-HALF){1'b0}}, pair};
  end
endmodule

// File: rtl/sfg_sequencer.sv
module sfg_sequencer
  import sfg_pkg::*;
#(
  parameter int SLOTS = 16,
  parameter int IDX_W = 4,
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] count_in,
  input  logic             ready,
  output logic             busy,
  output logic             last,
  output logic [IDX_W-1:0] aidx,
  output wsel_t            wsel,
  output logic             err
);
  localparam logic [CNT_W-1:0] MAX_N    = CNT_W'(SLOTS);
  localparam logic [IDX_W-1:0] LAST_SLT = IDX_W'(SLOTS-1);
  localparam wsel_t            LAST_W   = SEL_W'(WORDS_PER_SLOT-1);

  logic             busy_q, err_q;
  logic [IDX_W-1:0] slot_q, aidx_q;
  wsel_t            wsel_q;
  logic [CNT_W-1:0] n_q, n_clamped, aidx_nxt;
  logic             slot_end, frame_end, fire;

  always_comb begin
    n_clamped = (count_in > MAX_N) ? MAX_N : count_in;
    fire      = busy_q & ready;
    slot_end  = (wsel_q == LAST_W);
    frame_end = slot_end && (slot_q == LAST_SLT);
    aidx_nxt  = CNT_W'(aidx_q) + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      err_q  <= 1'b0;
      slot_q <= '0;
      aidx_q <= '0;
      wsel_q <= '0;
      n_q    <= '0;
    end else if (!busy_q) begin
      if (start) begin
        if (count_in == '0) begin
          err_q <= 1'b1;
        end else begin
          err_q  <= 1'b0;
          busy_q <= 1'b1;
          n_q    <= n_clamped;
          slot_q <= '0;
          aidx_q <= '0;
          wsel_q <= '0;
        end
      end
    end else if (fire) begin
      if (slot_end) begin
        wsel_q <= '0;
        slot_q <= slot_q + IDX_W'(1);
        aidx_q <= (aidx_nxt == n_q) ? '0 : IDX_W'(aidx_nxt);
        if (frame_end) busy_q <= 1'b0;
      end else begin
        wsel_q <= wsel_q + SEL_W'(1);
      end
    end
  end

  assign busy = busy_q;
  assign last = busy_q & frame_end;
  assign aidx = aidx_q;
  assign wsel = wsel_q;
  assign err  = err_q;

  // R4
  aidx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (CNT_W'(aidx_q) < n_q));

  // R7
  err_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_q && start && count_in == '0) |=> (err_q && !busy_q));
endmodule

// File: rtl/setup_frame_gen.sv
module setup_frame_gen
  import sfg_pkg::*;
#(
  parameter int SLOTS  = 16,
  parameter int ADDR_W = 48,
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tbl_we,
  input  logic [3:0]        tbl_idx,
  input  logic [ADDR_W-1:0] tbl_addr,
  input  logic [4:0]        cfg_count,
  input  logic              start,
  output logic              frm_valid,
  input  logic              frm_ready,
  output logic [WORD_W-1:0] frm_data,
  output logic              frm_last,
  output logic              cfg_err
);
  localparam int IDX_W = $clog2(SLOTS);
  localparam int CNT_W = $clog2(SLOTS + 1);

  logic [IDX_W-1:0]  rd_idx;
  logic [ADDR_W-1:0] rd_addr;
  wsel_t             wsel;

  sfg_addr_table #(.SLOTS(SLOTS), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_table (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (tbl_we),
    .wr_idx  (IDX_W'(tbl_idx)),
    .wr_data (tbl_addr),
    .rd_idx  (rd_idx),
    .rd_data (rd_addr)
  );

  sfg_sequencer #(.SLOTS(SLOTS), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .count_in (CNT_W'(cfg_count)),
    .ready    (frm_ready),
    .busy     (frm_valid),
    .last     (frm_last),
    .aidx     (rd_idx),
    .wsel     (wsel),
    .err      (cfg_err)
  );

  sfg_word_format #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_fmt (
    .addr (rd_addr),
    .wsel (wsel),
    .word (frm_data)
  );

  // R6
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_valid && !frm_ready) |=> (frm_valid && $stable(frm_data) && $stable(frm_last)));

  // R2
  last_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_valid && frm_ready && frm_last) |=> !frm_valid);

  // R2
  last_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frm_last |-> frm_valid);

  // R3
  upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frm_valid |-> (frm_data[WORD_W-1:WORD_W/2] == '0));

  // R8
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_valid && !frm_ready && start) |=> frm_valid);
endmodule

// File: tb/test_setup_frame_gen.sv
module test_setup_frame_gen;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        tbl_we = 0;
  logic [3:0]  tbl_idx = 0;
  logic [47:0] tbl_addr = 0;
  logic [4:0]  cfg_count = 0;
  logic        start = 0;
  logic        frm_ready = 0;
  logic        frm_valid, frm_last, cfg_err;
  logic [31:0] frm_data;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  int rdy_mode = 0;
  string cur_req = "R1";

  logic [47:0] tbl [16];
  logic [31:0] q [$];
  logic        m_err = 0;
  logic        was_empty;
  int          n_eff;

  always #5 clk = ~clk;

  setup_frame_gen i_setup_frame_gen (
    .clk(clk), .rst_n(rst_n), .tbl_we(tbl_we), .tbl_idx(tbl_idx),
    .tbl_addr(tbl_addr), .cfg_count(cfg_count), .start(start),
    .frm_valid(frm_valid), .frm_ready(frm_ready), .frm_data(frm_data),
    .frm_last(frm_last), .cfg_err(cfg_err)
  );

  // Reference model: builds the expected word list when a start is taken
  always @(posedge clk) begin
    if (rst_n) begin
      was_empty = (q.size() == 0);
      if (!was_empty && frm_ready) void'(q.pop_front());
      if (start && was_empty) begin
        n_eff = (cfg_count > 16) ? 16 : int'(cfg_count);
        if (n_eff == 0) m_err = 1;
        else begin
          m_err = 0;
          for (int k = 0; k < 16; k++) begin
            logic [47:0] a;
            a = tbl[k % n_eff];
            for (int j = 0; j < 3; j++)
              q.push_back({16'h0000, a[16*j+8 +: 8], a[16*j +: 8]});
          end
        end
      end
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp, string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s (%s, phase %s): actual %h expected %h", req, what, cur_req, act, exp);
    end
  endtask

  // Per-cycle comparison with the model
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R2", 32'(frm_valid), 32'(q.size() != 0), "valid");
      chk("R7", 32'(cfg_err), 32'(m_err), "err");
      if (q.size() != 0) begin
        chk("R3", frm_data, q[0], "data");
        chk("R2", 32'(frm_last), 32'(q.size() == 1), "last");
      end
    end
  end

  always @(negedge clk) begin
    case (rdy_mode)
      0: frm_ready <= 1'b1;
      1: frm_ready <= ~frm_ready;
      default: frm_ready <= 1'($urandom % 2);
    endcase
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic wr(int idx, logic [47:0] v);
    @(negedge clk);
    tbl_we = 1; tbl_idx = 4'(idx); tbl_addr = v;
    tbl[idx] = v;
    @(negedge clk);
    tbl_we = 0;
  endtask

  task automatic go(int n);
    @(negedge clk);
    start = 1; cfg_count = 5'(n);
    @(negedge clk);
    start = 0;
  endtask

  task automatic wait_done();
    while (q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) tbl[i] = '0;
    repeat (2) @(negedge clk);
    // R1: outputs quiet during reset
    chk("R1", 32'(frm_valid), 0, "valid in reset");
    chk("R1", 32'(cfg_err), 0, "err in reset");
    rst_n = 1;
    repeat (2) @(negedge clk);
    chk("R1", 32'(frm_valid), 0, "valid after reset");

    // R9: load table
    cur_req = "R9";
    for (int i = 0; i < 16; i++) wr(i, {$urandom, $urandom} & 48'hFFFF_FFFF_FFFF);

    cur_req = "R2"; rdy_mode = 0;
    go(16); wait_done();

    cur_req = "R4"; rdy_mode = 1;
    go(3); wait_done();

    cur_req = "R6"; rdy_mode = 2;
    go(1); wait_done();
    go(7); wait_done();

    cur_req = "R5"; rdy_mode = 2;
    go(20); wait_done();

    cur_req = "R7";
    go(0);
    repeat (5) @(negedge clk);
    chk("R7", 32'(cfg_err), 1, "err after zero count");
    chk("R7", 32'(frm_valid), 0, "no words on zero count");
    rdy_mode = 0;
    go(5); wait_done();
    chk("R7", 32'(cfg_err), 0, "err cleared");

    // R8: start mid-frame and on the final handshake
    cur_req = "R8"; rdy_mode = 0;
    go(4);
    repeat (10) @(negedge clk);
    start = 1; cfg_count = 2;
    @(negedge clk);
    start = 0;
    while (q.size() != 1) @(negedge clk);
    start = 1; cfg_count = 2;
    @(negedge clk);
    start = 0;
    repeat (3) @(negedge clk);
    chk("R8", 32'(frm_valid), 0, "no frame after ignored start");

    // R9: rewrite one entry and resend
    cur_req = "R9"; rdy_mode = 2;
    wr(0, 48'hA1B2_C3D4_E5F6);
    wr(2, 48'h0102_0304_0506);
    go(3); wait_done();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule